// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This execution unit takes one operand, a shift count and an incoming carry flag. It produces a shifted or rotated result and an outgoing carry flag. There are eight operation codes covering seven operations: logical shift left and right, arithmetic shift left and right, rotate left and right, and rotate left and right through the carry. The arithmetic left shift has its own code but behaves exactly like the logical left shift. For every shift, the outgoing carry holds the last bit that left the operand. The through-carry rotates treat the carry as one extra bit above the operand, so the rotation spans `WIDTH+1` bits.

The unit computes its result in one combinational pass. The result is captured into output registers on a valid strobe, so it appears one clock later. The count arrives as a plain value. The unit does not care whether it came from an immediate field or from a count register. Only the low count bits are used: 5 bits, or 6 bits when the operand is wider than 32 bits. A masked count of zero leaves both the operand and the carry unchanged.

Top module: `srot_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o`, `carry_o` and `valid_o` are all zero.
- R2: When `valid_i` is high at a rising edge, the new result and carry appear on the outputs after that edge, and `valid_o` is high for that one cycle. When `valid_i` is low, the outputs hold their values and `valid_o` is low.
- R3: Op 0 (logical left) and op 2 (arithmetic left) give identical results. Vacated low bits fill with zeros, and the carry is operand bit `WIDTH-n`. A count greater than `WIDTH` gives a zero result and a zero carry.
- R4: Op 1 (logical right) fills vacated high bits with zeros, and the carry is operand bit `n-1`. A count greater than `WIDTH` gives a zero result and a zero carry.
- R5: Op 3 (arithmetic right) replicates the sign bit, which rounds toward minus infinity, and the carry is operand bit `n-1`. For a count of `WIDTH` or more, every result bit equals the sign and the carry equals the sign.
- R6: Op 4 (rotate left) and op 5 (rotate right) rotate the operand by `n mod WIDTH`. The carry is result bit 0 for rotate left and result bit `WIDTH-1` for rotate right.
- R7: Op 6 and op 7 rotate the `WIDTH+1`-bit value {carry_i, operand} left and right by `n mod (WIDTH+1)`. The top bit of the rotated value becomes `carry_o` and the low `WIDTH` bits become `result_o`.
- R8: The count `n` is `count_i` masked to its low 5 bits (6 bits when `WIDTH` > 32). Higher count bits have no effect.
- R9: When the masked count is zero, for any op, `result_o` equals the operand and `carry_o` equals `carry_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe that captures a new operation |
| op_i | input | 3 | Operation code (0..7 as in R3 to R7) |
| operand_i | input | WIDTH | Value to shift or rotate |
| count_i | input | CNT_IN_W | Count value, masked inside the unit |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | WIDTH | Registered result |
| carry_o | output | 1 | Registered outgoing carry |
| valid_o | output | 1 | High for one cycle when new outputs are present |

## Verification
The bench builds the unit with the defaults: `WIDTH` = 8 and `CNT_IN_W` = 8.

At that width the 5-bit masked count reaches 31, far past the operand width. This makes the over-shift limits reachable: the zero results, the all-sign results, and a carry taken from the far end. It also exercises the modulo-8 and modulo-9 wrap of the two rotate families, including a 9-step through-carry rotate that returns the operand unchanged.

The 8-bit count input carries bits above the mask, so the masking of R8 can be observed at the ports.

// File: rtl/srot_pkg.sv
package srot_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAL = 3'd2,
    OP_SAR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } srot_op_e;
endpackage

// File: rtl/srot_shift.sv
module srot_shift
  import srot_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CW    = 5
) (
  input  srot_op_e           op_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [CW-1:0]      cnt_i,
  output logic [WIDTH-1:0]   r_o,
  output logic               c_o
);
  // One guard bit beside the operand catches the last bit shifted out
  logic [WIDTH:0]        lft;
  logic [WIDTH:0]        rgt;
  logic signed [WIDTH:0] ars;

  assign lft = {1'b0, a_i} << cnt_i;
  assign rgt = {a_i, 1'b0} >> cnt_i;
  assign ars = $signed({a_i, 1'b0}) >>> cnt_i;

  always_comb begin
    unique case (op_i)
      OP_SHR:  {r_o, c_o} = rgt;
      OP_SAR:  {r_o, c_o} = ars;
      default: {c_o, r_o} = lft;
    endcase
  end
endmodule

// File: rtl/srot_rotate.sv
module srot_rotate
  import srot_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CW    = 5
) (
  input  srot_op_e           op_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic               c_i,
  input  logic [CW-1:0]      cnt_i,
  output logic [WIDTH-1:0]   r_o,
  output logic               c_o
);
  localparam int W1 = WIDTH + 1;

  logic [CW-1:0]    k_plain;
  logic [CW-1:0]    k_carry;
  logic [WIDTH-1:0] rol_v, ror_v;
  logic [WIDTH:0]   ext_v, rcl_v, rcr_v;

  assign k_plain = CW'(int'(cnt_i) % WIDTH);
  assign k_carry = CW'(int'(cnt_i) % W1);

  assign rol_v = (a_i << k_plain) | (a_i >> (WIDTH - int'(k_plain)));
  assign ror_v = (a_i >> k_plain) | (a_i << (WIDTH - int'(k_plain)));

  // Carry sits above the operand and joins the rotation
  assign ext_v = {c_i, a_i};
  assign rcl_v = (ext_v << k_carry) | (ext_v >> (W1 - int'(k_carry)));
  assign rcr_v = (ext_v >> k_carry) | (ext_v << (W1 - int'(k_carry)));

  always_comb begin
    unique case (op_i)
      OP_ROL:  begin r_o = rol_v; c_o = rol_v[0];       end
      OP_ROR:  begin r_o = ror_v; c_o = ror_v[WIDTH-1]; end
      OP_RCL:  {c_o, r_o} = rcl_v;
      default: {c_o, r_o} = rcr_v;
    endcase
  end
endmodule

// File: rtl/srot_unit.sv
module srot_unit
  import srot_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int CNT_IN_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [2:0]          op_i,
  input  logic [WIDTH-1:0]    operand_i,
  input  logic [CNT_IN_W-1:0] count_i,
  input  logic                carry_i,
  output logic [WIDTH-1:0]    result_o,
  output logic                carry_o,
  output logic                valid_o
);
  localparam int CW = (WIDTH > 32) ? 6 : 5;

  srot_op_e         op;
  logic [CW-1:0]    cnt_m;
  logic [WIDTH-1:0] sh_r, ro_r, nxt_r;
  logic             sh_c, ro_c, nxt_c;
  logic             is_rot;

  assign op     = srot_op_e'(op_i);
  assign cnt_m  = count_i[CW-1:0];
  assign is_rot = op_i[2];

  srot_shift #(.WIDTH(WIDTH), .CW(CW)) u_shift (
    .op_i  (op),
    .a_i   (operand_i),
    .cnt_i (cnt_m),
    .r_o   (sh_r),
    .c_o   (sh_c)
  );

  srot_rotate #(.WIDTH(WIDTH), .CW(CW)) u_rotate (
    .op_i  (op),
    .a_i   (operand_i),
    .c_i   (carry_i),
    .cnt_i (cnt_m),
    .r_o   (ro_r),
    .c_o   (ro_c)
  );

  always_comb begin
    if (cnt_m == '0) begin
      nxt_r = operand_i;
      nxt_c = carry_i;
    end else if (is_rot) begin
      nxt_r = ro_r;
      nxt_c = ro_c;
    end else begin
      nxt_r = sh_r;
      nxt_c = sh_c;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= nxt_r;
        carry_o  <= nxt_c;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(carry_o))); // R2
  AST_SHL_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd0 || op_i == 3'd2) && cnt_m != '0) |=> !result_o[0]); // R3
  AST_SHR_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd1 && cnt_m != '0) |=> !result_o[WIDTH-1]); // R4
  AST_SAR_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3) |=> (result_o[WIDTH-1] == $past(operand_i[WIDTH-1]))); // R5
  AST_ROT_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd4 || op_i == 3'd5)) |=>
      ($countones(result_o) == $countones($past(operand_i)))); // R6
  AST_RCX_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd6 || op_i == 3'd7)) |=>
      ($countones({carry_o, result_o}) == $countones({$past(carry_i), $past(operand_i)}))); // R7
  AST_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cnt_m == '0) |=>
      (result_o == $past(operand_i) && carry_o == $past(carry_i))); // R9
endmodule

// File: tb/srot_unit_tb.sv
module srot_unit_tb;
  localparam int NV = 35;

  // {req, op, count, cin, operand, exp_result, exp_carry}
  localparam logic [32:0] VEC [NV] = '{
    {4'd3, 3'd0, 8'd1,  1'b0, 8'h81, 8'h02, 1'b1},  // R3
    {4'd3, 3'd0, 8'd1,  1'b0, 8'h02, 8'h04, 1'b0},  // R3
    {4'd3, 3'd2, 8'd1,  1'b0, 8'hFF, 8'hFE, 1'b1},  // R3 arithmetic left
    {4'd3, 3'd0, 8'd8,  1'b0, 8'h81, 8'h00, 1'b1},  // R3 count == width
    {4'd3, 3'd0, 8'd9,  1'b1, 8'hFF, 8'h00, 1'b0},  // R3 count > width
    {4'd3, 3'd2, 8'd3,  1'b0, 8'h3C, 8'hE0, 1'b1},  // R3
    {4'd4, 3'd1, 8'd1,  1'b0, 8'h04, 8'h02, 1'b0},  // R4
    {4'd4, 3'd1, 8'd1,  1'b0, 8'h81, 8'h40, 1'b1},  // R4
    {4'd4, 3'd1, 8'd4,  1'b1, 8'hF8, 8'h0F, 1'b1},  // R4
    {4'd4, 3'd1, 8'd8,  1'b0, 8'h80, 8'h00, 1'b1},  // R4 count == width
    {4'd4, 3'd1, 8'd12, 1'b1, 8'hFF, 8'h00, 1'b0},  // R4 count > width
    {4'd5, 3'd3, 8'd1,  1'b0, 8'hFF, 8'hFF, 1'b1},  // R5 -1 stays -1
    {4'd5, 3'd3, 8'd1,  1'b0, 8'hFE, 8'hFF, 1'b0},  // R5
    {4'd5, 3'd3, 8'd3,  1'b0, 8'h84, 8'hF0, 1'b1},  // R5
    {4'd5, 3'd3, 8'd20, 1'b0, 8'h80, 8'hFF, 1'b1},  // R5 count > width
    {4'd5, 3'd3, 8'd2,  1'b1, 8'h7C, 8'h1F, 1'b0},  // R5 positive
    {4'd6, 3'd4, 8'd1,  1'b0, 8'h81, 8'h03, 1'b1},  // R6
    {4'd6, 3'd4, 8'd1,  1'b1, 8'h03, 8'h06, 1'b0},  // R6
    {4'd6, 3'd5, 8'd2,  1'b0, 8'h06, 8'h81, 1'b1},  // R6
    {4'd6, 3'd5, 8'd1,  1'b0, 8'h81, 8'hC0, 1'b1},  // R6
    {4'd6, 3'd4, 8'd8,  1'b0, 8'hA5, 8'hA5, 1'b1},  // R6 full turn
    {4'd6, 3'd5, 8'd11, 1'b0, 8'h01, 8'h20, 1'b0},  // R6 wrap 11 -> 3
    {4'd6, 3'd4, 8'd12, 1'b1, 8'h96, 8'h69, 1'b1},  // R6 wrap 12 -> 4
    {4'd7, 3'd6, 8'd1,  1'b0, 8'h81, 8'h02, 1'b1},  // R7
    {4'd7, 3'd6, 8'd1,  1'b1, 8'h02, 8'h05, 1'b0},  // R7
    {4'd7, 3'd7, 8'd2,  1'b0, 8'h05, 8'h81, 1'b0},  // R7
    {4'd7, 3'd7, 8'd1,  1'b0, 8'h81, 8'h40, 1'b1},  // R7
    {4'd7, 3'd6, 8'd9,  1'b1, 8'h3C, 8'h3C, 1'b1},  // R7 full width+1 turn
    {4'd7, 3'd7, 8'd10, 1'b0, 8'h01, 8'h00, 1'b1},  // R7 wrap 10 -> 1
    {4'd8, 3'd0, 8'h21, 1'b0, 8'h81, 8'h02, 1'b1},  // R8 masked to 1
    {4'd8, 3'd4, 8'hE1, 1'b0, 8'h81, 8'h03, 1'b1},  // R8 masked to 1
    {4'd8, 3'd5, 8'h40, 1'b1, 8'hA5, 8'hA5, 1'b1},  // R8 masked to 0
    {4'd9, 3'd1, 8'd0,  1'b1, 8'hFF, 8'hFF, 1'b1},  // R9
    {4'd9, 3'd6, 8'd0,  1'b0, 8'h81, 8'h81, 1'b0},  // R9
    {4'd9, 3'd3, 8'h20, 1'b0, 8'h80, 8'h80, 1'b0}   // R9
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic [7:0] count_i = '0;
  logic       carry_i = 1'b0;
  logic [7:0] result_o;
  logic       carry_o;
  logic       valid_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5ns clk_i = ~clk_i;

  srot_unit u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .op_i      (op_i),
    .operand_i (operand_i),
    .count_i   (count_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .valid_o   (valid_o)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [7:0] cnt, input logic cin,
                       input logic [7:0] a);
    @(negedge clk_i);
    op_i = op; count_i = cnt; carry_i = cin; operand_i = a; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 10ns);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset", {valid_o, carry_o, result_o}, 10'h000);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      apply(v[28:26], v[25:18], v[17], v[16:9]);
      check($sformatf("R%0d vec %0d", v[32:29], i), {valid_o, carry_o, result_o},
            {1'b1, v[0], v[8:1]});
    end

    // R2: outputs hold while valid_i is low, valid_o drops
    apply(3'd4, 8'd1, 1'b0, 8'h81);
    @(negedge clk_i);
    op_i = 3'd1; count_i = 8'd3; carry_i = 1'b0; operand_i = 8'hF0;
    @(negedge clk_i);
    check("R2 hold", {valid_o, carry_o, result_o}, {1'b0, 1'b1, 8'h03});

    // R2: one cycle latency, valid_o high for exactly one cycle
    apply(3'd1, 8'd3, 1'b0, 8'hF0);
    check("R2 latency", {valid_o, carry_o, result_o}, {1'b1, 1'b0, 8'h1E});
    @(negedge clk_i);
    check("R2 valid pulse", {valid_o, carry_o, result_o}, {1'b0, 1'b0, 8'h1E});

    // R3: SAL and SHL match on a wide pattern
    apply(3'd0, 8'd5, 1'b1, 8'h5B);
    check("R3 shl 5", {valid_o, carry_o, result_o}, {1'b1, 1'b1, 8'h60});
    apply(3'd2, 8'd5, 1'b1, 8'h5B);
    check("R3 sal 5", {valid_o, carry_o, result_o}, {1'b1, 1'b1, 8'h60});

    // R1: asynchronous reset mid-run clears the outputs
    apply(3'd3, 8'd1, 1'b1, 8'hFF);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2ns;
    check("R1 async reset", {valid_o, carry_o, result_o}, 10'h000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule